// File: doc/BRIEF.md
# CAN-FD Bit-Rate Phase Controller

This block follows a CAN or CAN-FD frame one bit at a time and tells the bit-timing logic which rate the next bit uses: nominal or data. Each time the bit-timing logic samples a bit, it pulses a strobe and presents the sampled bus level. The controller moves through the frame fields, from the start-of-frame bit to the end of intermission. It keeps the format, rate-switch and error-state flags of the frame, and it raises a data-phase select for exactly those bits that an FD frame with rate switching sends fast.

The field code and the phase select always describe the bit that comes next. The timing logic can therefore load the matching prescaler before that bit starts. The payload byte count and the CRC length come from a DLC decoder and a CRC-length selector next to this block. Bit stuffing, arbitration loss, error frames and time-quantum generation belong to other blocks.

Top module: `canfd_rate_phase`

## Requirements
- R1: While reset is active and after reset is released, field_o is 0 (bus idle), phase_data_o is 0, and fdf_o, brs_o and esi_o are 0.
- R2: Outputs change only on a strobe. In the idle field, a strobed dominant bit (0) is the start of frame: it moves the field to the base identifier and clears all captured flags. A strobed recessive bit (1) leaves the field idle.
- R3: A recessive IDE bit leads to 18 extended identifier bits and one remote bit, then the format bit. A dominant IDE bit leads straight to the format bit.
- R4: A recessive format bit starts the FD control sequence: reserved, rate switch, error state, then 4 DLC bits. A dominant format bit gives a classical frame: 4 DLC bits follow at once for a base identifier, and one reserved bit then the DLC for an extended identifier. fdf_o holds the sampled format bit.
- R5: In an FD frame with a recessive rate-switch bit, phase_data_o is 1 from the bit after the rate-switch bit (the error-state bit) through the DLC, data and CRC fields.
- R6: phase_data_o is 0 from the CRC delimiter onward, through ACK, ACK delimiter, end of frame and intermission.
- R7: In an FD frame with a dominant rate-switch bit, phase_data_o stays 0 for the whole frame.
- R8: A classical frame never selects the data phase, and brs_o and esi_o stay 0, whatever level the bus carries in the bit after the format bit.
- R9: The data field lasts 8 × pay_bytes_i bits, with pay_bytes_i sampled on the strobe of the last DLC bit. A value of 0 leads directly to the CRC field.
- R10: A classical frame whose remote bit is recessive has no data field, whatever pay_bytes_i holds.
- R11: The CRC field lasts crc_len_i bits, with crc_len_i sampled on the strobe that enters the CRC field.
- R12: After the CRC field come a 1-bit CRC delimiter, a 1-bit ACK slot, a 1-bit ACK delimiter, 7 end-of-frame bits and 3 intermission bits, and then the idle field.
- R13: esi_o holds the sampled error-state bit of an FD frame: 1 means the sender is error-passive, 0 means error-active.
- R14: field_o encoding: 0 idle, 1 base identifier, 2 substitute/remote bit, 3 IDE, 4 extended identifier, 5 extended remote bit, 6 format bit, 7 reserved, 8 rate switch, 9 error state, 10 DLC, 11 data, 12 CRC, 13 CRC delimiter, 14 ACK, 15 ACK delimiter, 16 end of frame, 17 intermission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle pulse at the sample point of each bus bit |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| pay_bytes_i | input | 7 | Decoded payload byte count (0..64) |
| crc_len_i | input | 5 | Selected CRC field length in bits |
| phase_data_o | output | 1 | 1 = the next bit uses the data rate |
| field_o | output | 5 | Field code of the next bit |
| fdf_o | output | 1 | Captured format bit |
| brs_o | output | 1 | Captured rate-switch bit |
| esi_o | output | 1 | Captured error-state bit |

## Verification
The assertions assume a destuffed bit stream: one strobe per frame bit, separated by at least one cycle. They also assume that pay_bytes_i is 0..64 and that crc_len_i is nonzero whenever the block samples them. The stimulus sets both lengths before each start of frame and holds them for the whole frame. It leaves two idle cycles between strobes, and it builds every frame from the field layout, so no error or overload condition ever appears on the bus.

// File: rtl/canfd_phase_pkg.sv
package canfd_phase_pkg;
  localparam int unsigned FLD_W        = 5;
  localparam int unsigned BASE_ID_BITS = 11;
  localparam int unsigned EXT_ID_BITS  = 18;
  localparam int unsigned DLC_BITS     = 4;
  localparam int unsigned EOF_BITS     = 7;
  localparam int unsigned IFS_BITS     = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_IDLE    = 5'd0,
    FLD_ID_A    = 5'd1,
    FLD_SRR_RTR = 5'd2,
    FLD_IDE     = 5'd3,
    FLD_ID_B    = 5'd4,
    FLD_RTR_B   = 5'd5,
    FLD_FDF     = 5'd6,
    FLD_RES     = 5'd7,
    FLD_BRS     = 5'd8,
    FLD_ESI     = 5'd9,
    FLD_DLC     = 5'd10,
    FLD_DATA    = 5'd11,
    FLD_CRC     = 5'd12,
    FLD_CRC_DEL = 5'd13,
    FLD_ACK     = 5'd14,
    FLD_ACK_DEL = 5'd15,
    FLD_EOF     = 5'd16,
    FLD_IFS     = 5'd17
  } fld_e;
endpackage

// File: rtl/canfd_ctrl_flags.sv
module canfd_ctrl_flags
  import canfd_phase_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic bus_bit_i,
  input  fld_e fld_i,
  output logic ide_o,
  output logic rtr_o,
  output logic fdf_o,
  output logic brs_o,
  output logic esi_o
);
  logic ide_q, rtr_q, fdf_q, brs_q, esi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ide_q <= 1'b0;
      rtr_q <= 1'b0;
      fdf_q <= 1'b0;
      brs_q <= 1'b0;
      esi_q <= 1'b0;
    end else if (bit_stb_i) begin
      case (fld_i)
        FLD_IDLE: if (!bus_bit_i) begin
          ide_q <= 1'b0;
          rtr_q <= 1'b0;
          fdf_q <= 1'b0;
          brs_q <= 1'b0;
          esi_q <= 1'b0;
        end
        FLD_SRR_RTR: rtr_q <= bus_bit_i;  // base remote bit; overwritten for extended ids
        FLD_IDE:     ide_q <= bus_bit_i;
        FLD_RTR_B:   rtr_q <= bus_bit_i;
        FLD_FDF:     fdf_q <= bus_bit_i;
        FLD_BRS:     brs_q <= bus_bit_i;
        FLD_ESI:     esi_q <= bus_bit_i;
        default: ;
      endcase
    end
  end

  assign ide_o = ide_q;
  assign rtr_o = rtr_q;
  assign fdf_o = fdf_q;
  assign brs_o = brs_q;
  assign esi_o = esi_q;

  AST_SOF_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && fld_i == FLD_IDLE && !bus_bit_i) |=> (!fdf_q && !brs_q && !esi_q)); // R2
  AST_CLASSIC_NO_BRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fdf_q |-> (!brs_q && !esi_q)); // R8
endmodule

// File: rtl/canfd_field_seq.sv
module canfd_field_seq
  import canfd_phase_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 64,
  parameter int unsigned CRC_MAX   = 21,
  localparam int unsigned BYTES_W  = $clog2(MAX_BYTES + 1),
  localparam int unsigned CRC_W    = $clog2(CRC_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_stb_i,
  input  logic               bus_bit_i,
  input  logic [BYTES_W-1:0] pay_bytes_i,
  input  logic [CRC_W-1:0]   crc_len_i,
  input  logic               ide_i,
  input  logic               rtr_i,
  input  logic               fdf_i,
  output fld_e               fld_o
);
  localparam int unsigned DATA_MAX = MAX_BYTES * 8;
  localparam int unsigned LEN_MAX  = (DATA_MAX > 32) ? DATA_MAX : 32;
  localparam int unsigned CNT_W    = $clog2(LEN_MAX);
  localparam int unsigned LEN_W    = CNT_W + 1;

  fld_e             fld_q, fld_d, nf;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len;

  // field of the next bit, and its length
  always_comb begin
    nf  = FLD_IDLE;
    len = LEN_W'(1);
    case (fld_q)
      FLD_IDLE:    if (!bus_bit_i) begin nf = FLD_ID_A; len = LEN_W'(BASE_ID_BITS); end
      FLD_ID_A:    nf = FLD_SRR_RTR;
      FLD_SRR_RTR: nf = FLD_IDE;
      FLD_IDE:     if (bus_bit_i) begin nf = FLD_ID_B; len = LEN_W'(EXT_ID_BITS); end
                   else nf = FLD_FDF;
      FLD_ID_B:    nf = FLD_RTR_B;
      FLD_RTR_B:   nf = FLD_FDF;
      FLD_FDF:     if (bus_bit_i || ide_i) nf = FLD_RES;
                   else begin nf = FLD_DLC; len = LEN_W'(DLC_BITS); end
      FLD_RES:     if (fdf_i) nf = FLD_BRS;
                   else begin nf = FLD_DLC; len = LEN_W'(DLC_BITS); end
      FLD_BRS:     nf = FLD_ESI;
      FLD_ESI:     begin nf = FLD_DLC; len = LEN_W'(DLC_BITS); end
      FLD_DLC:     if ((rtr_i && !fdf_i) || pay_bytes_i == '0) begin
                     nf = FLD_CRC; len = LEN_W'(crc_len_i);
                   end else begin
                     nf = FLD_DATA; len = LEN_W'({pay_bytes_i, 3'b000});
                   end
      FLD_DATA:    begin nf = FLD_CRC; len = LEN_W'(crc_len_i); end
      FLD_CRC:     nf = FLD_CRC_DEL;
      FLD_CRC_DEL: nf = FLD_ACK;
      FLD_ACK:     nf = FLD_ACK_DEL;
      FLD_ACK_DEL: begin nf = FLD_EOF; len = LEN_W'(EOF_BITS); end
      FLD_EOF:     begin nf = FLD_IFS; len = LEN_W'(IFS_BITS); end
      FLD_IFS:     nf = FLD_IDLE;
      default:     nf = FLD_IDLE;
    endcase
  end

  always_comb begin
    fld_d = fld_q;
    cnt_d = cnt_q;
    if (bit_stb_i) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        fld_d = nf;
        cnt_d = CNT_W'(len - 1'b1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q <= FLD_IDLE;
      cnt_q <= '0;
    end else begin
      fld_q <= fld_d;
      cnt_q <= cnt_d;
    end
  end

  assign fld_o = fld_q;

  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> $stable(fld_q)); // R2
  AST_SOF_ENTERS_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && fld_q == FLD_IDLE && !bus_bit_i) |=> fld_q == FLD_ID_A); // R2
  AST_EMPTY_SKIPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && fld_q == FLD_DLC && cnt_q == '0 && pay_bytes_i == '0) |=> fld_q == FLD_CRC); // R9
  AST_IFS_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld_q == FLD_IDLE && $past(fld_q) != FLD_IDLE) |-> $past(fld_q) == FLD_IFS); // R12
endmodule

// File: rtl/canfd_rate_sel.sv
module canfd_rate_sel
  import canfd_phase_pkg::*;
(
  input  fld_e fld_i,
  input  logic fdf_i,
  input  logic brs_i,
  output logic phase_data_o
);
  logic fast_fld;

  always_comb begin
    case (fld_i)
      FLD_ESI, FLD_DLC, FLD_DATA, FLD_CRC: fast_fld = 1'b1;
      default:                             fast_fld = 1'b0;
    endcase
  end

  assign phase_data_o = fdf_i & brs_i & fast_fld;
endmodule

// File: rtl/canfd_rate_phase.sv
module canfd_rate_phase
  import canfd_phase_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 64,
  parameter int unsigned CRC_MAX   = 21,
  localparam int unsigned BYTES_W  = $clog2(MAX_BYTES + 1),
  localparam int unsigned CRC_W    = $clog2(CRC_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_stb_i,
  input  logic               bus_bit_i,
  input  logic [BYTES_W-1:0] pay_bytes_i,
  input  logic [CRC_W-1:0]   crc_len_i,
  output logic               phase_data_o,
  output logic [FLD_W-1:0]   field_o,
  output logic               fdf_o,
  output logic               brs_o,
  output logic               esi_o
);
  fld_e fld;
  logic ide, rtr, fdf, brs, esi;

  canfd_field_seq #(
    .MAX_BYTES (MAX_BYTES),
    .CRC_MAX   (CRC_MAX)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_stb_i   (bit_stb_i),
    .bus_bit_i   (bus_bit_i),
    .pay_bytes_i (pay_bytes_i),
    .crc_len_i   (crc_len_i),
    .ide_i       (ide),
    .rtr_i       (rtr),
    .fdf_i       (fdf),
    .fld_o       (fld)
  );

  canfd_ctrl_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_stb_i (bit_stb_i),
    .bus_bit_i (bus_bit_i),
    .fld_i     (fld),
    .ide_o     (ide),
    .rtr_o     (rtr),
    .fdf_o     (fdf),
    .brs_o     (brs),
    .esi_o     (esi)
  );

  canfd_rate_sel u_rate (
    .fld_i        (fld),
    .fdf_i        (fdf),
    .brs_i        (brs),
    .phase_data_o (phase_data_o)
  );

  assign field_o = fld;
  assign fdf_o   = fdf;
  assign brs_o   = brs;
  assign esi_o   = esi;

  AST_RISE_AFTER_BRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_data_o) |-> ($past(fld) == FLD_BRS && fld == FLD_ESI)); // R5
  AST_FALL_AT_DELIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phase_data_o) |-> fld == FLD_CRC_DEL); // R6
  AST_FAST_NEEDS_FD_BRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_data_o |-> (fdf && brs)); // R7
  AST_ACK_NOMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld == FLD_ACK || fld == FLD_EOF || fld == FLD_IDLE) |-> !phase_data_o); // R6
endmodule

// File: tb/canfd_rate_phase_tb_top.sv
`timescale 1ns/1ps
module canfd_rate_phase_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_stb_i = 1'b0;
  logic       bus_bit_i = 1'b1;
  logic [6:0] pay_bytes_i = '0;
  logic [4:0] crc_len_i = 5'd15;
  logic       phase_data_o;
  logic [4:0] field_o;
  logic       fdf_o, brs_o, esi_o;

  always #2.5 clk_i = ~clk_i;

  canfd_rate_phase dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_stb_i    (bit_stb_i),
    .bus_bit_i    (bus_bit_i),
    .pay_bytes_i  (pay_bytes_i),
    .crc_len_i    (crc_len_i),
    .phase_data_o (phase_data_o),
    .field_o      (field_o),
    .fdf_o        (fdf_o),
    .brs_o        (brs_o),
    .esi_o        (esi_o)
  );

  localparam int F_IDLE = 0, F_ID_A = 1, F_SRR = 2, F_IDE = 3, F_ID_B = 4, F_RTR_B = 5,
                 F_FDF = 6, F_RES = 7, F_BRS = 8, F_ESI = 9, F_DLC = 10, F_DATA = 11,
                 F_CRC = 12, F_CDEL = 13, F_ACK = 14, F_ADEL = 15, F_EOF = 16, F_IFS = 17;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  int    bit_v[$];
  int    fld_v[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add(input int f, input int n, input int kind);
    for (int k = 0; k < n; k++) begin
      fld_v.push_back(f);
      bit_v.push_back(kind == 2 ? (k % 2) : kind);
    end
  endtask

  task automatic strobe(input int b, input int nf, input bit fast, input string tag);
    @(negedge clk_i);
    bus_bit_i = b[0];
    bit_stb_i = 1'b1;
    exp_q.push_back({fast, 5'(nf)});
    tag_q.push_back(tag);
    @(negedge clk_i);
    bit_stb_i = 1'b0;
    bus_bit_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic send_frame(input bit ext, input bit fd, input bit brs, input bit esi,
                            input bit rtr, input int bytes, input int crcl, input string tag);
    int nd;
    bit_v.delete();
    fld_v.delete();
    pay_bytes_i = 7'(bytes);
    crc_len_i   = 5'(crcl);
    add(F_IDLE, 1, 0);
    add(F_ID_A, 11, 2);
    if (ext) begin
      add(F_SRR, 1, 1);
      add(F_IDE, 1, 1);
      add(F_ID_B, 18, 2);
      add(F_RTR_B, 1, fd ? 0 : int'(rtr));
    end else begin
      add(F_SRR, 1, fd ? 0 : int'(rtr));
      add(F_IDE, 1, 0);
    end
    add(F_FDF, 1, int'(fd));
    if (fd) begin
      add(F_RES, 1, 0);
      add(F_BRS, 1, int'(brs));
      add(F_ESI, 1, int'(esi));
    end else if (ext) begin
      add(F_RES, 1, 0);
    end
    add(F_DLC, 4, 1);  // recessive in the slot after the format/reserved bit
    nd = (!fd && rtr) ? 0 : bytes * 8;
    if (nd > 0) add(F_DATA, nd, 2);
    add(F_CRC, crcl, 2);
    add(F_CDEL, 1, 1);
    add(F_ACK, 1, 0);
    add(F_ADEL, 1, 1);
    add(F_EOF, 7, 1);
    add(F_IFS, 3, 1);
    for (int i = 0; i < bit_v.size(); i++) begin
      int  nf;
      bit  fast;
      nf   = (i + 1 < fld_v.size()) ? fld_v[i + 1] : F_IDLE;
      fast = fd && brs && (nf == F_ESI || nf == F_DLC || nf == F_DATA || nf == F_CRC);
      strobe(bit_v[i], nf, fast, tag);
    end
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    chk(fdf_o == fd, "R4", int'(fdf_o), int'(fd));
    if (fd) begin
      chk(brs_o == brs, "R5", int'(brs_o), int'(brs));
      chk(esi_o == esi, "R13", int'(esi_o), int'(esi));
    end else begin
      chk(brs_o == 1'b0, "R8", int'(brs_o), 0);
      chk(esi_o == 1'b0, "R8", int'(esi_o), 0);
    end
  endtask

  // monitor: compare each strobed bit's result against the scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      if (bit_stb_i) begin
        logic [5:0] e;
        string      t, tf, tp;
        @(negedge clk_i);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", 0, 1);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          tf = (int'(e[4:0]) >= F_CDEL) ? "R12" : (int'(e[4:0]) == F_ID_A) ? "R14" : t;
          tp = (int'(e[4:0]) >= F_CDEL) ? "R6" : t;
          chk(field_o == e[4:0], tf, int'(field_o), int'(e[4:0]));
          chk(phase_data_o == e[5], tp, int'(phase_data_o), int'(e[5]));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(field_o == 5'd0 && phase_data_o == 1'b0, "R1", int'(field_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(field_o == 5'd0, "R14", int'(field_o), 0);
    chk(phase_data_o == 1'b0, "R1", int'(phase_data_o), 0);
    chk({fdf_o, brs_o, esi_o} == 3'b000, "R1", int'({fdf_o, brs_o, esi_o}), 0);

    // recessive strobes in idle; dominant level without strobe
    strobe(1, F_IDLE, 1'b0, "R2");
    strobe(1, F_IDLE, 1'b0, "R2");
    @(negedge clk_i);
    bus_bit_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(field_o == 5'd0, "R2", int'(field_o), 0);
    bus_bit_i = 1'b1;

    send_frame(0, 1, 1, 0, 0, 16, 17, "R5");
    send_frame(1, 1, 1, 1, 0, 64, 21, "R11");
    send_frame(0, 1, 0, 1, 0, 8, 17, "R7");
    send_frame(0, 0, 0, 0, 0, 8, 15, "R4");
    send_frame(1, 0, 0, 0, 0, 2, 15, "R3");
    send_frame(0, 0, 0, 0, 1, 4, 15, "R10");
    send_frame(1, 0, 0, 0, 1, 8, 15, "R10");
    send_frame(0, 1, 1, 0, 0, 0, 17, "R9");
    send_frame(1, 1, 1, 0, 0, 12, 17, "R3");

    // a new start of frame clears the flags left by the previous FD frame
    send_frame(0, 1, 1, 1, 0, 1, 17, "R13");
    strobe(0, F_ID_A, 1'b0, "R2");
    chk({fdf_o, brs_o, esi_o} == 3'b000, "R2", int'({fdf_o, brs_o, esi_o}), 0);

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule